// File: doc/BRIEF.md
# Fully Terminated Turbo Encoder

This block turns a block of N information bits into a rate-1/3 coded stream. Two identical recursive systematic convolutional encoders, each with three memory cells, run side by side. The first sees the bits in arrival order. The second sees them in a permuted order given by a quadratic permutation polynomial. Both encoders start every block from the all-zero state.

After the information triplets, each encoder is flushed back to zero with its own three tail cycles. The second encoder is terminated after the permutation as well, so a decoder knows the end state of both trellises.

Bits arrive one per handshake with a block-start marker. The whole block is held in a register buffer before any output is produced. Output is a contiguous run with no back-pressure: N data triplets, then three tail pairs from the first encoder, then three tail pairs from the second. While that run is in progress the input is not ready.

Top module: `turbo_term_enc`

## Requirements
- R1: After reset `in_ready` is 1 and `out_valid` is 0.
- R2: A bit is accepted when `in_valid` and `in_ready` are both high. An accepted bit with `in_first` high becomes bit 0 of a new block and discards any partly loaded block. An accepted bit with `in_first` low, offered while no block is being loaded, is discarded and produces no output.
- R3: After the N-th bit of a block is accepted, `in_ready` is low for exactly N+6 cycles. No data triplet is ever presented while `in_ready` is high.
- R4: The first output appears in the second cycle after the N-th bit is accepted. Data triplet i (i = 0..N-1) carries `out_phase` = 0 and `out_sys` equal to bit i of the block.
- R5: Each constituent encoder has cells s1, s2, s3 and starts each block at zero. For an input u it computes a = u^s2^s3 and parity a^s1^s3, then shifts a into s1. This is feedback polynomial 13 octal and forward polynomial 15 octal. During data triplets, `out_p1` is the first encoder's parity for bit i.
- R6: During data triplet i, `out_p2` is the second encoder's parity for input bit pi(i) = (F1*i + F2*i*i) mod N. The defaults are N=40, F1=3, F2=10.
- R7: After the data triplets, three outputs with `out_phase` = 1 flush the first encoder. Each carries `out_sys` = s2^s3 (the tail bit), `out_p1` = s1^s3 and `out_p2` = 0. The first encoder is then in the all-zero state.
- R8: Next, three outputs with `out_phase` = 2 flush the second encoder. Each carries `out_sys` = s2^s3 of that encoder, `out_p2` = s1^s3 and `out_p1` = 0. The second encoder is then in the all-zero state.
- R9: `out_valid` stays high for exactly N+6 consecutive cycles per block and is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input bit offered |
| in_bit | input | 1 | Information bit |
| in_first | input | 1 | Marks the first bit of a block |
| in_ready | output | 1 | Block accepts a bit this cycle |
| out_valid | output | 1 | Output fields are valid |
| out_phase | output | 2 | 0 data, 1 first-encoder tail, 2 second-encoder tail |
| out_sys | output | 1 | Systematic bit or tail bit |
| out_p1 | output | 1 | First encoder parity |
| out_p2 | output | 1 | Second encoder parity |

## Verification
The assertions take for granted that reset is applied before the first block and that `in_bit` and `in_first` carry known levels whenever `in_valid` is high. Given that, the ordering of phases, the ready/valid exclusion and the zero encoder states after each tail follow from the block alone.

The stimulus drives only 0 or 1 and changes inputs on falling clock edges. It holds `in_valid` low between bits when it inserts gaps, and it offers stray unmarked bits and an interrupted partial block only while the block is idle or loading.

// File: rtl/turbo_term_enc.sv
module turbo_term_enc #(
  parameter int N  = 40,
  parameter int F1 = 3,
  parameter int F2 = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic       in_bit,
  input  logic       in_first,
  output logic       in_ready,
  output logic       out_valid,
  output logic [1:0] out_phase,
  output logic       out_sys,
  output logic       out_p1,
  output logic       out_p2
);
  localparam int AW = $clog2(N);
  localparam logic [AW-1:0] LAST  = AW'(N - 1);
  localparam logic [AW-1:0] G0    = AW'((F1 + F2) % N);
  localparam logic [AW-1:0] GSTEP = AW'((2 * F2) % N);
  localparam logic [AW:0]   NW    = (AW+1)'(N);

  typedef enum logic [1:0] {LOAD, DATA, TAIL1, TAIL2} st_t;

  st_t           st;
  logic [N-1:0]  blk;
  logic [AW-1:0] cnt, pi, gi;
  logic [1:0]    tc;
  logic [2:0]    st1, st2;

  logic u1, u2, a1, a2, p1, p2;
  logic [AW:0] psum, gsum;

  assign in_ready = (st == LOAD);

  assign u1 = (st == DATA) ? blk[cnt] : (st1[1] ^ st1[2]);
  assign u2 = (st == DATA) ? blk[pi]  : (st2[1] ^ st2[2]);
  assign a1 = u1 ^ st1[1] ^ st1[2];
  assign a2 = u2 ^ st2[1] ^ st2[2];
  assign p1 = a1 ^ st1[0] ^ st1[2];
  assign p2 = a2 ^ st2[0] ^ st2[2];

  assign psum = {1'b0, pi} + {1'b0, gi};
  assign gsum = {1'b0, gi} + {1'b0, GSTEP};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= LOAD;
      blk       <= '0;
      cnt       <= '0;
      pi        <= '0;
      gi        <= '0;
      tc        <= '0;
      st1       <= '0;
      st2       <= '0;
      out_valid <= 1'b0;
      out_phase <= 2'd0;
      out_sys   <= 1'b0;
      out_p1    <= 1'b0;
      out_p2    <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      case (st)
        LOAD: if (in_valid) begin
          if (in_first) begin
            blk[0] <= in_bit;
            cnt    <= AW'(1);
          end else if (cnt != '0) begin
            blk[cnt] <= in_bit;
            if (cnt == LAST) begin
              st  <= DATA;
              cnt <= '0;
              pi  <= '0;
              gi  <= G0;
              st1 <= '0;
              st2 <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        DATA: begin
          out_valid <= 1'b1;
          out_phase <= 2'd0;
          out_sys   <= u1;
          out_p1    <= p1;
          out_p2    <= p2;
          st1       <= {st1[1:0], a1};
          st2       <= {st2[1:0], a2};
          pi        <= (psum >= NW) ? AW'(psum - NW) : AW'(psum);
          gi        <= (gsum >= NW) ? AW'(gsum - NW) : AW'(gsum);
          cnt       <= cnt + 1'b1;
          if (cnt == LAST) begin
            st <= TAIL1;
            tc <= '0;
          end
        end
        TAIL1: begin
          out_valid <= 1'b1;
          out_phase <= 2'd1;
          out_sys   <= u1;
          out_p1    <= p1;
          out_p2    <= 1'b0;
          st1       <= {st1[1:0], a1};
          tc        <= tc + 1'b1;
          if (tc == 2'd2) begin
            st <= TAIL2;
            tc <= '0;
          end
        end
        default: begin
          out_valid <= 1'b1;
          out_phase <= 2'd2;
          out_sys   <= u2;
          out_p1    <= 1'b0;
          out_p2    <= p2;
          st2       <= {st2[1:0], a2};
          tc        <= tc + 1'b1;
          if (tc == 2'd2) begin
            st  <= LOAD;
            cnt <= '0;
            tc  <= '0;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/turbo_term_enc_chk.sv
module turbo_term_enc_chk #(
  parameter int N = 40
) (
  input logic       clk,
  input logic       rst_n,
  input logic       in_ready,
  input logic       out_valid,
  input logic [1:0] out_phase,
  input logic       out_p1,
  input logic       out_p2,
  input logic [2:0] st1,
  input logic [2:0] st2
);
  localparam int CW = $clog2(N + 1);
  logic [CW-1:0] dcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dcnt <= '0;
    else if (out_valid && out_phase == 2'd0) dcnt <= dcnt + 1'b1;
    else if (out_valid) dcnt <= '0;
  end

  a_r3_no_data_while_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_phase == 2'd0) |-> !in_ready);

  a_r4_data_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_phase == 2'd0) |-> (dcnt < CW'(N)));

  a_r7_enc1_flushed: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_phase == 2'd2 && $past(out_valid) && $past(out_phase) == 2'd1) |-> (st1 == 3'd0));

  a_r7_tail1_p2_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_phase == 2'd1) |-> !out_p2);

  a_r8_enc2_flushed: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_valid) |-> (st2 == 3'd0));

  a_r8_tail2_p1_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_phase == 2'd2) |-> !out_p1);

  a_r9_tail_contiguous: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_phase != 2'd0) |-> $past(out_valid));
endmodule

bind turbo_term_enc turbo_term_enc_chk #(.N(N)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
  .out_phase(out_phase), .out_p1(out_p1), .out_p2(out_p2), .st1(st1), .st2(st2)
);

// File: tb/turbo_term_enc_tb.sv
`timescale 1ns/1ps
module turbo_term_enc_tb;
  localparam int N = 40, F1 = 3, F2 = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_bit = 1'b0, in_first = 1'b0;
  logic in_ready, out_valid, out_sys, out_p1, out_p2;
  logic [1:0] out_phase;

  int checks = 0, fails = 0, run = 0;
  logic [4:0] exp_q[$];

  always #2 clk = ~clk;

  turbo_term_enc #(.N(N), .F1(F1), .F2(F2)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_bit(in_bit), .in_first(in_first),
    .in_ready(in_ready), .out_valid(out_valid), .out_phase(out_phase),
    .out_sys(out_sys), .out_p1(out_p1), .out_p2(out_p2));

  task automatic check(input logic ok, input string what, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, expv);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  task automatic push_model(input logic [N-1:0] bits);
    logic [2:0] s1 = 3'd0, s2 = 3'd0;
    for (int i = 0; i < N; i++) begin
      logic u, v, a, b, q1, q2;
      u = bits[i];
      v = bits[(F1 * i + F2 * i * i) % N];
      a = u ^ s1[1] ^ s1[2]; q1 = a ^ s1[0] ^ s1[2]; s1 = {s1[1:0], a};
      b = v ^ s2[1] ^ s2[2]; q2 = b ^ s2[0] ^ s2[2]; s2 = {s2[1:0], b};
      exp_q.push_back({2'd0, u, q1, q2});
    end
    for (int t = 0; t < 3; t++) begin
      exp_q.push_back({2'd1, s1[1] ^ s1[2], s1[0] ^ s1[2], 1'b0});
      s1 = {s1[1:0], 1'b0};
    end
    for (int t = 0; t < 3; t++) begin
      exp_q.push_back({2'd2, s2[1] ^ s2[2], 1'b0, s2[0] ^ s2[2]});
      s2 = {s2[1:0], 1'b0};
    end
    check(s1 == 3'd0 && s2 == 3'd0, "R7/R8 model end state", int'({s1, s2}), 0);
  endtask

  task automatic send_bit(input logic b, input logic f);
    logic acc;
    in_valid = 1'b1; in_bit = b; in_first = f;
    do begin
      acc = in_ready;
      @(negedge clk);
    end while (!acc);
    in_valid = 1'b0; in_first = 1'b0;
  endtask

  task automatic run_block(input logic [N-1:0] bits, input int gap);
    int n;
    push_model(bits);
    for (int i = 0; i < N; i++) begin
      send_bit(bits[i], i == 0);
      if (i != N - 1) repeat (gap) @(negedge clk);
    end
    n = 0;
    while (!in_ready && n < 4 * N) begin
      if (n == 0) check(out_valid == 1'b0, "R4 no output before latency", out_valid, 0);
      if (n == 1) check(out_valid == 1'b1 && out_phase == 2'd0, "R4 first triplet timing", out_valid, 1);
      n++;
      @(negedge clk);
    end
    check(n == N + 6, "R3 ready low cycles", n, N + 6);
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid) begin
        run++;
        if (exp_q.size() == 0) begin
          check(1'b0, "R9 unexpected output", int'({out_phase, out_sys, out_p1, out_p2}), -1);
        end else begin
          logic [4:0] e, a;
          e = exp_q.pop_front();
          a = {out_phase, out_sys, out_p1, out_p2};
          case (e[4:3])
            2'd0: check(a == e, "R4/R5/R6 data triplet", int'(a), int'(e));
            2'd1: check(a == e, "R7 first encoder tail", int'(a), int'(e));
            default: check(a == e, "R8 second encoder tail", int'(a), int'(e));
          endcase
        end
      end else if (run != 0) begin
        check(run == N + 6, "R9 output run length", run, N + 6);
        run = 0;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "R9 watchdog expired", 0, 1);
    summary();
    $finish;
  end

  initial begin
    logic [N-1:0] v;
    repeat (3) @(negedge clk);
    check(in_ready == 1'b1, "R1 reset ready", in_ready, 1);
    check(out_valid == 1'b0, "R1 reset valid", out_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: unmarked bits while idle are dropped
    for (int i = 0; i < 5; i++) send_bit(1'b1, 1'b0);
    repeat (5) begin
      check(out_valid == 1'b0 && in_ready == 1'b1, "R2 stray bits ignored", out_valid, 0);
      @(negedge clk);
    end

    run_block('0, 0);
    run_block('1, 1);
    for (int i = 0; i < N; i++) v[i] = i[0];
    run_block(v, 0);
    v = '0; v[N-1] = 1'b1;
    run_block(v, 2);
    v = '0; v[0] = 1'b1;
    run_block(v, 0);

    // R2: partial block interrupted by a new marker
    for (int i = 0; i < 10; i++) send_bit(1'b1, i == 0);
    v = {$urandom, $urandom};
    run_block(v, 0);

    for (int k = 0; k < 3; k++) begin
      v = {$urandom, $urandom};
      run_block(v, k);
    end

    repeat (N + 20) @(negedge clk);
    check(exp_q.size() == 0, "R9 all expected outputs seen", exp_q.size(), 0);
    check(out_valid == 1'b0, "R9 idle after blocks", out_valid, 0);
    summary();
    $finish;
  end
endmodule